// File: doc/BRIEF.md
# Fetch Direction and Target Predictor

This block sits at the front of the instruction fetch pipeline and chooses the address of the next fetch block in every cycle. It keeps a running fetch PC. For that PC it looks up a table of two-bit saturating counters and a small tagged buffer of branch targets. When the counter leans towards taken and the target buffer holds an entry for that exact PC, the block steers fetch to the stored target. In every other case fetch moves on sequentially by one whole fetch block of four instructions.

A taken prediction is not free. The fetch slot right after it is empty, and fetch resumes at the target on the cycle after that empty slot. Execute sends one update port per resolved branch, carrying the branch PC, the actual direction and the actual target. The update trains the counter, and on a taken outcome it also refreshes the target entry. A separate steering input lets the back end force fetch to any address, for example after a misprediction. This input overrides every prediction.

Top module: `fetch_redirect_predictor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `fetch_pc` equals the reset address (default 0), `fetch_valid` is 1, `pred_taken` is 0 and `next_pc` is the reset address plus 16.
- R2: When no taken prediction is made and no steering is applied, the next valid fetch PC is the current one plus 16 bytes (four 4-byte instructions), and `next_pc` shows that value.
- R3: Each direction counter is two bits wide and starts at 1 after reset. A resolved taken update adds one, stopping at 3. A not-taken update subtracts one, stopping at 0. Counter values 2 and 3 lean taken.
- R4: `pred_taken` is 1 only when three conditions hold together: the fetch slot is valid, the counter leans taken, and the target entry at that PC's index is valid with a tag equal to PC bits [31:8]. A PC that shares a counter but has a different tag predicts sequential.
- R5: A not-taken update never changes the target buffer, so the previously stored target is still predicted.
- R6: A taken update writes its actual target into the target buffer. A later taken prediction for that PC shows this most recent target on `next_pc`.
- R7: After a valid cycle with `pred_taken`=1, the following cycle has `fetch_valid`=0. The cycle after that has `fetch_valid`=1 and `fetch_pc` equal to the predicted target.
- R8: When an update and a lookup hit the same entry in the same cycle, the lookup sees the contents from before the update. The update becomes visible from the next cycle on.
- R9: When `redirect_valid` is asserted, the next cycle has `fetch_valid`=1 and `fetch_pc`=`redirect_pc`. This holds even if the current cycle is a taken prediction or an empty slot.
- R10: The 512 counters are indexed by PC bits [10:2]. The 64 target entries are indexed by PC bits [7:2]. Branches with different counter indices train independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_valid | input | 1 | Force fetch to `redirect_pc` next cycle |
| redirect_pc | input | 32 | Forced fetch address |
| upd_valid | input | 1 | Resolved branch update present |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target address |
| fetch_pc | output | 32 | Address of the current fetch block |
| fetch_valid | output | 1 | Current fetch slot is real (0 in the redirect bubble) |
| pred_taken | output | 1 | Current fetch block is predicted to branch away |
| next_pc | output | 32 | Predicted address of the next fetch block |

## Verification
The bench walks several branches, each with its own index, through mixed direction patterns and checks each prediction against an arithmetic counter model. A counter that fails to saturate or starts at the wrong value then shows up as a wrong prediction, and a target that is overwritten on a not-taken outcome shows up as a wrong `next_pc`. Each check samples in the same cycle as the update to that entry, so a design that forwards the update would predict one step early. An aliasing PC with the same index but a different tag catches a buffer that ignores tags. Timed runs through a taken prediction check the single empty slot, the resume address, and steering that arrives inside the bubble, so a missing or doubled bubble is caught.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_MIN      = 2'd0;
   localparam ctr_t CTR_MAX      = 2'd3;
   localparam ctr_t CTR_WEAK_NT  = 2'd1;

   // saturating step of a two-bit direction counter
   function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
      ctr_t res;
      if (taken) res = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
      else       res = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
      return res;
   endfunction

   // upper half of the range leans taken
   function automatic logic ctr_leans_taken(input ctr_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
   import bpred_pkg::*;
#(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned ENTRIES = 512,
   parameter int unsigned IDX_LO  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_taken,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic            wr_taken
);
   localparam int unsigned IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("bp_dir_table: ENTRIES must be a power of two of at least 2");
   end
   if (IDX_LO + IDX_W > PC_W) begin : g_bad_index
      $error("bp_dir_table: index field exceeds PC width");
   end

   ctr_t             ctr_q [ENTRIES];
   logic [IDX_W-1:0] rd_idx;
   logic [IDX_W-1:0] wr_idx;

   assign rd_idx = rd_pc[IDX_LO +: IDX_W];
   assign wr_idx = wr_pc[IDX_LO +: IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < int'(ENTRIES); e++) ctr_q[e] <= CTR_WEAK_NT;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= ctr_next(ctr_q[wr_idx], wr_taken);
      end
   end

   // read sees registered contents: a same-cycle write is not forwarded
   assign rd_taken = ctr_leans_taken(ctr_q[rd_idx]);

endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned IDX_LO  = 2,
   parameter int unsigned TAG_W   = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_hit,
   output logic [PC_W-1:0] rd_target,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic [PC_W-1:0] wr_target
);
   localparam int unsigned IDX_W      = $clog2(ENTRIES);
   localparam int unsigned FULL_TAG_W = PC_W - IDX_LO - IDX_W;
   localparam int unsigned USE_TAG_W  = (TAG_W == 0) ? FULL_TAG_W : TAG_W;

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("bp_target_buf: ENTRIES must be a power of two of at least 2");
   end
   if (IDX_LO + IDX_W >= PC_W) begin : g_bad_index
      $error("bp_target_buf: no PC bits left for the tag");
   end
   if (USE_TAG_W > FULL_TAG_W) begin : g_bad_tag
      $error("bp_target_buf: TAG_W wider than the bits above the index");
   end

   logic                 vld_q [ENTRIES];
   logic [USE_TAG_W-1:0] tag_q [ENTRIES];
   logic [PC_W-1:0]      tgt_q [ENTRIES];

   logic [IDX_W-1:0]     rd_idx;
   logic [IDX_W-1:0]     wr_idx;
   logic [USE_TAG_W-1:0] rd_tag;
   logic [USE_TAG_W-1:0] wr_tag;

   assign rd_idx = rd_pc[IDX_LO +: IDX_W];
   assign wr_idx = wr_pc[IDX_LO +: IDX_W];

   // full tag compares every bit above the index; a partial tag keeps the low ones
   if (USE_TAG_W == FULL_TAG_W) begin : g_full_tag
      assign rd_tag = rd_pc[PC_W-1 -: USE_TAG_W];
      assign wr_tag = wr_pc[PC_W-1 -: USE_TAG_W];
   end else begin : g_part_tag
      assign rd_tag = rd_pc[IDX_LO+IDX_W +: USE_TAG_W];
      assign wr_tag = wr_pc[IDX_LO+IDX_W +: USE_TAG_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < int'(ENTRIES); e++) vld_q[e] <= 1'b0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_target;
      end
   end

   assign rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_target = tgt_q[rd_idx];

endmodule

// File: rtl/bp_pc_gen.sv
module bp_pc_gen #(
   parameter int unsigned      PC_W     = 32,
   parameter int unsigned      STEP     = 16,
   parameter logic [PC_W-1:0]  RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            redirect_valid,
   input  logic [PC_W-1:0] redirect_pc,
   input  logic            take,
   input  logic [PC_W-1:0] take_target,
   output logic [PC_W-1:0] fetch_pc,
   output logic            fetch_valid,
   output logic [PC_W-1:0] next_pc
);
   if (STEP == 0) begin : g_bad_step
      $error("bp_pc_gen: STEP must be non-zero");
   end

   logic [PC_W-1:0] pc_q;
   logic            bubble_q;
   logic [PC_W-1:0] seq_pc;

   assign seq_pc = pc_q + PC_W'(STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= RESET_PC;
         bubble_q <= 1'b0;
      end else if (redirect_valid) begin
         pc_q     <= redirect_pc;
         bubble_q <= 1'b0;
      end else if (bubble_q) begin
         bubble_q <= 1'b0;
      end else if (take) begin
         pc_q     <= take_target;
         bubble_q <= 1'b1;
      end else begin
         pc_q     <= seq_pc;
      end
   end

   assign fetch_pc    = pc_q;
   assign fetch_valid = !bubble_q;
   assign next_pc     = take ? take_target : seq_pc;

endmodule

// File: rtl/fetch_redirect_predictor.sv
module fetch_redirect_predictor #(
   parameter int unsigned     PC_W        = 32,
   parameter int unsigned     FETCH_WIDTH = 4,
   parameter int unsigned     INSTR_BYTES = 4,
   parameter int unsigned     DIR_ENTRIES = 512,
   parameter int unsigned     TGT_ENTRIES = 64,
   parameter int unsigned     TGT_TAG_W   = 0,
   parameter logic [PC_W-1:0] RESET_PC    = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            redirect_valid,
   input  logic [PC_W-1:0] redirect_pc,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target,
   output logic [PC_W-1:0] fetch_pc,
   output logic            fetch_valid,
   output logic            pred_taken,
   output logic [PC_W-1:0] next_pc
);
   localparam int unsigned IDX_LO = $clog2(INSTR_BYTES);
   localparam int unsigned STEP   = FETCH_WIDTH * INSTR_BYTES;

   if (FETCH_WIDTH == 0) begin : g_bad_width
      $error("fetch_redirect_predictor: FETCH_WIDTH must be at least 1");
   end
   if ((1 << IDX_LO) != INSTR_BYTES) begin : g_bad_ibytes
      $error("fetch_redirect_predictor: INSTR_BYTES must be a power of two");
   end

   logic            dir_taken;
   logic            tgt_hit;
   logic [PC_W-1:0] tgt_addr;

   bp_dir_table #(
      .PC_W    (PC_W),
      .ENTRIES (DIR_ENTRIES),
      .IDX_LO  (IDX_LO)
   ) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_pc    (fetch_pc),
      .rd_taken (dir_taken),
      .wr_en    (upd_valid),
      .wr_pc    (upd_pc),
      .wr_taken (upd_taken)
   );

   bp_target_buf #(
      .PC_W    (PC_W),
      .ENTRIES (TGT_ENTRIES),
      .IDX_LO  (IDX_LO),
      .TAG_W   (TGT_TAG_W)
   ) u_tgt (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_pc     (fetch_pc),
      .rd_hit    (tgt_hit),
      .rd_target (tgt_addr),
      .wr_en     (upd_valid && upd_taken),
      .wr_pc     (upd_pc),
      .wr_target (upd_target)
   );

   assign pred_taken = fetch_valid && dir_taken && tgt_hit;

   bp_pc_gen #(
      .PC_W     (PC_W),
      .STEP     (STEP),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk            (clk),
      .rst_n          (rst_n),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc),
      .take           (pred_taken),
      .take_target    (tgt_addr),
      .fetch_pc       (fetch_pc),
      .fetch_valid    (fetch_valid),
      .next_pc        (next_pc)
   );

endmodule

// File: rtl/fetch_redirect_predictor_chk.sv
module fetch_redirect_predictor_chk #(
   parameter int unsigned     PC_W     = 32,
   parameter int unsigned     STEP     = 16,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            redirect_valid,
   input logic [PC_W-1:0] redirect_pc,
   input logic [PC_W-1:0] fetch_pc,
   input logic            fetch_valid,
   input logic            pred_taken
);

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_state_R1: assert (fetch_pc == RESET_PC && fetch_valid && !pred_taken)
            else $error("reset state wrong");
      end
   end

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !pred_taken && !redirect_valid)
      |=> (fetch_valid && fetch_pc == $past(fetch_pc) + PC_W'(STEP)));

   assert_pred_needs_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> fetch_valid);

   assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_taken && !redirect_valid) |=> !fetch_valid);

   assert_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_valid && !redirect_valid) |=> (fetch_valid && $stable(fetch_pc)));

   assert_steer_R9: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> (fetch_valid && fetch_pc == $past(redirect_pc)));

endmodule

bind fetch_redirect_predictor fetch_redirect_predictor_chk #(
   .PC_W     (PC_W),
   .STEP     (FETCH_WIDTH * INSTR_BYTES),
   .RESET_PC (RESET_PC)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .redirect_valid (redirect_valid),
   .redirect_pc    (redirect_pc),
   .fetch_pc       (fetch_pc),
   .fetch_valid    (fetch_valid),
   .pred_taken     (pred_taken)
);

// File: tb/fetch_redirect_predictor_tb.sv
module fetch_redirect_predictor_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        redirect_valid = 1'b0;
   logic [31:0] redirect_pc = '0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_target = '0;
   logic [31:0] fetch_pc;
   logic        fetch_valid;
   logic        pred_taken;
   logic [31:0] next_pc;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   fetch_redirect_predictor u_dut (
      .clk(clk), .rst_n(rst_n),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
      .fetch_pc(fetch_pc), .fetch_valid(fetch_valid), .pred_taken(pred_taken), .next_pc(next_pc)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   // steer fetch to p and keep it there
   task automatic hold(input logic [31:0] p);
      redirect_valid = 1'b1;
      redirect_pc    = p;
      cyc();
   endtask

   task automatic train(input logic [31:0] p, input bit tk, input logic [31:0] t);
      upd_valid = 1'b1; upd_pc = p; upd_taken = tk; upd_target = t;
      cyc();
      upd_valid = 1'b0;
   endtask

   // counter/target sweep: check in the same cycle as each update (old value)
   task automatic sweep();
      for (int k = 0; k < 8; k++) begin
         logic [31:0] p;
         logic [31:0] bt;
         logic [11:0] pat;
         int          cnt;
         bit          bv;
         bit          et;
         p   = 32'h0000_1000 + 32'(k * 36);
         pat = 12'hB3E ^ 12'(k * 12'h159);
         cnt = 1; bv = 1'b0; bt = '0;
         hold(p);
         for (int i = 0; i < 12; i++) begin
            logic [31:0] nt;
            nt = 32'h0040_0000 + 32'(k * 32'h1000) + 32'(i * 32);
            upd_valid = 1'b1; upd_pc = p; upd_taken = pat[i]; upd_target = nt;
            #2;
            et = bv && (cnt >= 2);
            chk("R3/R8 direction", {31'b0, pred_taken}, {31'b0, et});
            chk("R6/R5 next_pc", next_pc, et ? bt : p + 32'd16);
            chk("R9 held fetch_pc", fetch_pc, p);
            cyc();
            upd_valid = 1'b0;
            if (pat[i]) begin
               cnt = (cnt == 3) ? 3 : cnt + 1;
               bv  = 1'b1;
               bt  = nt;
            end else begin
               cnt = (cnt == 0) ? 0 : cnt - 1;
            end
         end
         #2;
         et = bv && (cnt >= 2);
         chk("R3 final direction", {31'b0, pred_taken}, {31'b0, et});
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      // R1 reset state
      repeat (3) cyc();
      #2;
      chk("R1 fetch_pc", fetch_pc, 32'h0);
      chk("R1 fetch_valid", {31'b0, fetch_valid}, 32'd1);
      chk("R1 pred_taken", {31'b0, pred_taken}, 32'd0);
      chk("R1 next_pc", next_pc, 32'h10);
      @(posedge clk); #1;
      rst_n = 1'b1;
      #2;
      chk("R1 first cycle fetch_pc", fetch_pc, 32'h0);
      cyc(); #2;
      chk("R2 sequential step", fetch_pc, 32'h10);
      cyc(); #2;
      chk("R2 sequential step 2", fetch_pc, 32'h20);
      chk("R2 next_pc", next_pc, 32'h30);

      sweep();

      // R6: last taken target wins
      hold(32'h1000);
      train(32'h1000, 1'b1, 32'h0090_0000);
      train(32'h1000, 1'b1, 32'h0090_0000);
      train(32'h1000, 1'b1, 32'h0090_0000);
      #2;
      chk("R6 taken", {31'b0, pred_taken}, 32'd1);
      chk("R6 target", next_pc, 32'h0090_0000);

      // R4: same indices, different tag
      hold(32'h2000);
      #2;
      chk("R4 alias not taken", {31'b0, pred_taken}, 32'd0);
      chk("R4 alias next_pc", next_pc, 32'h2010);

      // R5: not-taken leaves target alone (counter 3 -> 2)
      hold(32'h1000);
      train(32'h1000, 1'b0, 32'h00AA_0000);
      #2;
      chk("R5 still taken", {31'b0, pred_taken}, 32'd1);
      chk("R5 target kept", next_pc, 32'h0090_0000);
      train(32'h1000, 1'b0, 32'h00AA_0000);
      #2;
      chk("R3 drop to 1", {31'b0, pred_taken}, 32'd0);
      train(32'h1000, 1'b1, 32'h0090_0000);
      #2;
      chk("R3 back to 2", {31'b0, pred_taken}, 32'd1);

      // R7: bubble then resume at target
      hold(32'h1000);
      redirect_valid = 1'b0;
      #2;
      chk("R7 predicting", {31'b0, pred_taken}, 32'd1);
      cyc(); #2;
      chk("R7 bubble", {31'b0, fetch_valid}, 32'd0);
      chk("R7 bubble no pred", {31'b0, pred_taken}, 32'd0);
      cyc(); #2;
      chk("R7 resume valid", {31'b0, fetch_valid}, 32'd1);
      chk("R7 resume pc", fetch_pc, 32'h0090_0000);
      cyc(); #2;
      chk("R2 after resume", fetch_pc, 32'h0090_0010);

      // R9: steering inside the bubble
      hold(32'h1000);
      redirect_valid = 1'b0;
      cyc();
      redirect_valid = 1'b1; redirect_pc = 32'h3000;
      #2;
      chk("R9 in bubble", {31'b0, fetch_valid}, 32'd0);
      cyc();
      redirect_valid = 1'b0;
      #2;
      chk("R9 steered pc", fetch_pc, 32'h3000);
      chk("R9 steered valid", {31'b0, fetch_valid}, 32'd1);
      cyc(); #2;
      chk("R9 then sequential", fetch_pc, 32'h3010);

      // R10: separate counters for different indices
      hold(32'h5004);
      train(32'h5004, 1'b1, 32'h00B0_0000);
      train(32'h5004, 1'b1, 32'h00B0_0000);
      train(32'h5004, 1'b1, 32'h00B0_0000);
      train(32'h5408, 1'b0, 32'h0);
      #2;
      chk("R10 first branch taken", next_pc, 32'h00B0_0000);
      train(32'h5408, 1'b1, 32'h00C0_0000);
      hold(32'h5408);
      #2;
      chk("R10 second own counter", {31'b0, pred_taken}, 32'd0);
      chk("R10 second next_pc", next_pc, 32'h5418);
      train(32'h5408, 1'b1, 32'h00C0_0000);
      #2;
      chk("R10 second now taken", next_pc, 32'h00C0_0000);
      hold(32'h5004);
      #2;
      chk("R10 first kept target", next_pc, 32'h00B0_0000);
      redirect_valid = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule